// File: doc/BRIEF.md
# Port Pattern-Match Detector

This block watches an input port of synchronized bits and decides, every clock, whether the port satisfies a programmed pattern. Each bit gets its own condition from three configuration words: a mask, a transition select and a polarity. Together they give five per-bit choices: ignore the bit, react to any edge, require a level, require a rising edge, or require a falling edge. A mode field combines the per-bit results in one of three ways:

- AND mode: every bit that takes part must match.
- OR mode: any one bit is enough.
- Vector mode: OR matching, plus a number that names the highest matching bit.

The block raises a match flag and an interrupt request from that result.

In the two plain modes the flag is edge-triggered on the combined result and stays set until software clears it. In vector mode the flag follows the combined result level on every sample. A latch option freezes the reported port value at the moment of a match, so software can read what caused it. Vector mode cannot be used together with latching.

Top module: `port_match_unit`

## Requirements
- R1: While reset is low, and after it is released, `match_o`, `irq_o`, `vec_o` and `port_q_o` are all zero, and every configuration word is zero.
- R2: A write with `cfg_sel_i` = 1, 2 or 3 loads the polarity, transition or mask word. For bit i:
  - mask=0, transition=0: the bit is ignored.
  - mask=0, transition=1: the bit hits on any change from the previous sample.
  - mask=1, transition=0: the bit hits when the port bit equals polarity.
  - mask=1, transition=1: the bit hits on a rising edge if polarity is 1 and on a falling edge if polarity is 0.
  
  Outputs reflect the sample taken at a clock edge from just after that edge.
- R3: AND mode (mode field 01) gives a combined match when at least one bit takes part and every bit that takes part hits on the same sample. If no bit takes part, there is never a match.
- R4: OR mode (mode field 10) gives a combined match when any bit hits.
- R5: In AND and OR modes the match flag is set only on a sample where the combined match goes from false to true. It then stays set until a sample with `flag_clr_i` high. If a set and a clear fall on the same sample, the set wins.
- R6: In vector mode (mode field 11), the following hold on every sample:
  - The flag equals the combined OR match.
  - `flag_clr_i` has no effect.
  - `vec_o` gives the index of the highest-numbered hitting bit.
- R7: Vector mode with the latch bit set never raises the match flag.
- R8: A write with `cfg_sel_i` = 0 loads the mode word: bit 0 is the latch bit, bits [2:1] are the mode field and bit 3 is the interrupt enable. Mode field 00 holds the match flag at zero.
- R9: `irq_o` is high exactly when the match flag is high and the interrupt enable bit is set.
- R10: When the latch bit is set and the flag is high, `port_q_o` holds the port sample that set the flag. Otherwise `port_q_o` shows the most recent sample.
- R11: `vec_o` is zero whenever vector mode is not matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_i | input | WIDTH | Synchronized port bits |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Configuration word select: 0 mode, 1 polarity, 2 transition, 3 mask |
| cfg_data_i | input | WIDTH | Configuration write data |
| flag_clr_i | input | 1 | Clears the sticky match flag in the edge-triggered modes |
| match_o | output | 1 | Match flag |
| irq_o | output | 1 | Interrupt request |
| vec_o | output | $clog2(WIDTH) | Index of the highest matching bit in vector mode |
| port_q_o | output | WIDTH | Port sample, either latched or transparent |

## Verification
The assertions assume that `port_i` is already synchronized and changes only between clock edges. They also assume the configuration is written as single-cycle strobes, so a mode change never coincides with a data-driven match decision that matters.

The stimulus respects this in two ways:
- It drives ports on the falling edge.
- Before each new configuration, it parks the block in the disabled mode with a non-matching all-zero port. As a result, the first edge-detect sample of every test starts from a known previous value and no stale combined match.

// File: rtl/pm_pkg.sv
package pm_pkg;
   typedef enum logic [1:0] {
      PM_OFF = 2'b00,
      PM_AND = 2'b01,
      PM_OR  = 2'b10,
      PM_PEV = 2'b11
   } pm_mode_e;

   localparam logic [1:0] SEL_MODE = 2'd0;
   localparam logic [1:0] SEL_POL  = 2'd1;
   localparam logic [1:0] SEL_TRN  = 2'd2;
   localparam logic [1:0] SEL_MSK  = 2'd3;
endpackage

// File: rtl/pm_bit_cell.sv
module pm_bit_cell (
   input  logic cur_i,
   input  logic prev_i,
   input  logic pol_i,
   input  logic trn_i,
   input  logic msk_i,
   output logic care_o,
   output logic hit_o
);
   always_comb begin
      care_o = msk_i | trn_i;
      unique case ({msk_i, trn_i})
         2'b00:   hit_o = 1'b0;
         2'b01:   hit_o = cur_i ^ prev_i;
         2'b10:   hit_o = (cur_i == pol_i);
         default: hit_o = pol_i ? (cur_i & ~prev_i) : (~cur_i & prev_i);
      endcase
   end
endmodule

// File: rtl/pm_combine.sv
module pm_combine
   import pm_pkg::*;
#(
   parameter int unsigned WIDTH = 8,
   localparam int unsigned IDX_W = $clog2(WIDTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  pm_mode_e         mode_i,
   input  logic [WIDTH-1:0] care_i,
   input  logic [WIDTH-1:0] hit_i,
   output logic             any_o,
   output logic [IDX_W-1:0] idx_o
);
   logic and_ok;
   logic or_ok;

   assign and_ok = (|care_i) && (&(~care_i | hit_i));
   assign or_ok  = |hit_i;

   always_comb begin
      unique case (mode_i)
         PM_AND:  any_o = and_ok;
         PM_OR,
         PM_PEV:  any_o = or_ok;
         default: any_o = 1'b0;
      endcase
   end

   always_comb begin
      idx_o = '0;
      for (int i = 0; i < int'(WIDTH); i++) begin
         if (hit_i[i]) idx_o = IDX_W'(i);
      end
   end

   // R6: the encoded index names a hitting bit with no higher hit above it
   assert_pev_top_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == PM_PEV && any_o) |-> ((hit_i >> idx_o) == WIDTH'(1)));
endmodule

// File: rtl/pm_flag_ctrl.sv
module pm_flag_ctrl
   import pm_pkg::*;
#(
   parameter int unsigned WIDTH    = 8,
   parameter bit          LATCH_EN = 1'b1,
   localparam int unsigned IDX_W   = $clog2(WIDTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  pm_mode_e         mode_i,
   input  logic             latch_i,
   input  logic             any_i,
   input  logic [IDX_W-1:0] idx_i,
   input  logic             clr_i,
   input  logic [WIDTH-1:0] sample_i,
   input  logic [WIDTH-1:0] sample_q_i,
   output logic             flag_o,
   output logic [IDX_W-1:0] vec_o,
   output logic [WIDTH-1:0] port_q_o
);
   logic             latch_eff;
   logic             trans_mode;
   logic             pev_mode;
   logic             pev_block;
   logic             set_evt;
   logic             any_prev_q;
   logic             flag_q;
   logic [IDX_W-1:0] vec_q;
   logic [WIDTH-1:0] held;

   assign latch_eff  = LATCH_EN && latch_i;
   assign trans_mode = (mode_i == PM_AND) || (mode_i == PM_OR);
   assign pev_block  = (mode_i == PM_PEV) && latch_eff;
   assign pev_mode   = (mode_i == PM_PEV) && !latch_eff;
   assign set_evt    = trans_mode && any_i && !any_prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         any_prev_q <= 1'b0;
         flag_q     <= 1'b0;
         vec_q      <= '0;
      end else begin
         any_prev_q <= any_i;
         vec_q      <= (pev_mode && any_i) ? idx_i : '0;
         if (mode_i == PM_OFF || pev_block) flag_q <= 1'b0;
         else if (pev_mode)                 flag_q <= any_i;
         else if (set_evt)                  flag_q <= 1'b1;
         else if (clr_i)                    flag_q <= 1'b0;
      end
   end

   generate
      if (LATCH_EN) begin : g_latch
         logic [WIDTH-1:0] hold_q;
         always_ff @(posedge clk) begin
            if (!rst_n)                 hold_q <= '0;
            else if (set_evt && !flag_q) hold_q <= sample_i;
         end
         assign held = hold_q;

         // R10: a frozen sample stays put while the flag remains set
         assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (latch_eff && flag_q && $past(flag_q) && $past(latch_eff)) |-> $stable(hold_q));
      end else begin : g_nolatch
         assign held = '0;
      end
   endgenerate

   assign flag_o   = flag_q;
   assign vec_o    = vec_q;
   assign port_q_o = (latch_eff && flag_q) ? held : sample_q_i;

   // R8: disabled mode leaves the flag low on the next sample
   assert_off_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == PM_OFF) |=> !flag_q);

   // R5: a false-to-true combined transition always sets the flag
   assert_rise_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (trans_mode && any_i && !any_prev_q) |=> flag_q);

   // R5: without such a transition a clear flag stays clear
   assert_no_spurious_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (trans_mode && !flag_q && !(any_i && !any_prev_q)) |=> !flag_q);

   // R7: vector mode combined with latching never flags
   assert_pev_latch_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pev_block |=> !flag_q);
endmodule

// File: rtl/port_match_unit.sv
module port_match_unit
   import pm_pkg::*;
#(
   parameter int unsigned WIDTH    = 8,
   parameter bit          LATCH_EN = 1'b1,
   localparam int unsigned IDX_W   = $clog2(WIDTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] port_i,
   input  logic             cfg_we_i,
   input  logic [1:0]       cfg_sel_i,
   input  logic [WIDTH-1:0] cfg_data_i,
   input  logic             flag_clr_i,
   output logic             match_o,
   output logic             irq_o,
   output logic [IDX_W-1:0] vec_o,
   output logic [WIDTH-1:0] port_q_o
);
   generate
      if (WIDTH < 4 || WIDTH > 256) begin : g_bad_width
         $error("port_match_unit: WIDTH must lie in 4..256");
      end
   endgenerate

   pm_mode_e         mode_q;
   logic             latch_q;
   logic             irq_en_q;
   logic [WIDTH-1:0] pol_q;
   logic [WIDTH-1:0] trn_q;
   logic [WIDTH-1:0] msk_q;
   logic [WIDTH-1:0] sample_q;
   logic [WIDTH-1:0] care;
   logic [WIDTH-1:0] hit;
   logic             any;
   logic [IDX_W-1:0] idx;
   logic             flag;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q   <= PM_OFF;
         latch_q  <= 1'b0;
         irq_en_q <= 1'b0;
         pol_q    <= '0;
         trn_q    <= '0;
         msk_q    <= '0;
         sample_q <= '0;
      end else begin
         sample_q <= port_i;
         if (cfg_we_i) begin
            unique case (cfg_sel_i)
               SEL_MODE: begin
                  latch_q  <= cfg_data_i[0];
                  mode_q   <= pm_mode_e'(cfg_data_i[2:1]);
                  irq_en_q <= cfg_data_i[3];
               end
               SEL_POL: pol_q <= cfg_data_i;
               SEL_TRN: trn_q <= cfg_data_i;
               default: msk_q <= cfg_data_i;
            endcase
         end
      end
   end

   generate
      for (genvar g = 0; g < int'(WIDTH); g++) begin : g_cell
         pm_bit_cell u_cell (
            .cur_i  (port_i[g]),
            .prev_i (sample_q[g]),
            .pol_i  (pol_q[g]),
            .trn_i  (trn_q[g]),
            .msk_i  (msk_q[g]),
            .care_o (care[g]),
            .hit_o  (hit[g])
         );
      end
   endgenerate

   pm_combine #(.WIDTH(WIDTH)) u_comb (
      .clk    (clk),
      .rst_n  (rst_n),
      .mode_i (mode_q),
      .care_i (care),
      .hit_i  (hit),
      .any_o  (any),
      .idx_o  (idx)
   );

   pm_flag_ctrl #(.WIDTH(WIDTH), .LATCH_EN(LATCH_EN)) u_flag (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_i     (mode_q),
      .latch_i    (latch_q),
      .any_i      (any),
      .idx_i      (idx),
      .clr_i      (flag_clr_i),
      .sample_i   (port_i),
      .sample_q_i (sample_q),
      .flag_o     (flag),
      .vec_o      (vec_o),
      .port_q_o   (port_q_o)
   );

   assign match_o = flag;
   assign irq_o   = flag && irq_en_q;
endmodule

// File: tb/sim_port_match_unit.sv
module sim_port_match_unit;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] port = 8'h00;
   logic       we = 1'b0;
   logic [1:0] sel = 2'd0;
   logic [7:0] wdata = 8'h00;
   logic       clr = 1'b0;
   logic       match;
   logic       irq;
   logic [2:0] vec;
   logic [7:0] port_q;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   port_match_unit u0 (
      .clk(clk), .rst_n(rst_n), .port_i(port), .cfg_we_i(we), .cfg_sel_i(sel),
      .cfg_data_i(wdata), .flag_clr_i(clr), .match_o(match), .irq_o(irq),
      .vec_o(vec), .port_q_o(port_q)
   );

   // rows: {port, clear, expected flag}; AND mode, bit0 level-high, bit1 rising
   localparam logic [9:0] TBL [14] = '{
      {8'h00, 2'b00}, {8'h01, 2'b00}, {8'h03, 2'b01}, {8'h03, 2'b01},
      {8'h03, 2'b10}, {8'h01, 2'b00}, {8'hF3, 2'b01}, {8'hF3, 2'b10},
      {8'h02, 2'b00}, {8'h03, 2'b00}, {8'h00, 2'b00}, {8'h03, 2'b01},
      {8'h00, 2'b10}, {8'h03, 2'b11}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cfg(input logic [1:0] s, input logic [7:0] d);
      @(negedge clk);
      we = 1'b1; sel = s; wdata = d; clr = 1'b0;
      @(posedge clk); #1;
      we = 1'b0;
   endtask

   task automatic step(input logic [7:0] p, input logic c);
      @(negedge clk);
      port = p; clr = c;
      @(posedge clk); #1;
   endtask

   task automatic quiesce();
      cfg(2'd0, 8'h00);
      step(8'h00, 1'b0);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=done");
         summary();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R1 match in reset", match, 0);
      chk("R1 irq in reset", irq, 0);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      chk("R1 vec after reset", vec, 0);
      chk("R1 port_q after reset", port_q, 0);
      chk("R1 match after reset", match, 0);

      // R3 R5 R9 R10 R11 table walk
      cfg(2'd1, 8'h03); cfg(2'd2, 8'h02); cfg(2'd3, 8'h03); cfg(2'd0, 8'h0A);
      foreach (TBL[i]) begin
         step(TBL[i][9:2], TBL[i][1]);
         chk($sformatf("R5 R3 row %0d flag", i), match, TBL[i][0]);
         chk($sformatf("R9 row %0d irq", i), irq, TBL[i][0]);
         chk($sformatf("R10 row %0d port_q", i), port_q, TBL[i][9:2]);
         chk($sformatf("R11 row %0d vec", i), vec, 0);
      end

      // R4 R2: OR mode, bit7 level-high, bit4 any edge, others ignored
      quiesce();
      cfg(2'd1, 8'h80); cfg(2'd2, 8'h10); cfg(2'd3, 8'h80); cfg(2'd0, 8'h0C);
      step(8'h80, 1'b0); chk("R4 level hit sets", match, 1);
      step(8'h80, 1'b1); chk("R5 sustained match does not re-set", match, 0);
      step(8'h90, 1'b0); chk("R5 still true no new set", match, 0);
      step(8'h10, 1'b0); chk("R4 no hit", match, 0);
      step(8'h00, 1'b0); chk("R2 any-edge fall hits", match, 1);
      step(8'h0F, 1'b1); chk("R2 ignored bits toggle no match", match, 0);

      // R2: falling edge when polarity is 0
      quiesce();
      cfg(2'd1, 8'h00); cfg(2'd2, 8'h01); cfg(2'd3, 8'h01); cfg(2'd0, 8'h0C);
      step(8'h01, 1'b0); chk("R2 rise ignored for falling spec", match, 0);
      step(8'h00, 1'b0); chk("R2 fall hits", match, 1);

      // R6: vector mode, all bits level-high
      quiesce();
      cfg(2'd1, 8'hFF); cfg(2'd2, 8'h00); cfg(2'd3, 8'hFF); cfg(2'd0, 8'h0E);
      step(8'h24, 1'b0); chk("R6 flag", match, 1); chk("R6 vec 5", vec, 5);
      step(8'h01, 1'b0); chk("R6 flag bit0", match, 1); chk("R6 vec 0", vec, 0);
      step(8'h01, 1'b1); chk("R6 clear ignored", match, 1);
      step(8'h81, 1'b0); chk("R6 vec 7", vec, 7);
      step(8'h00, 1'b0); chk("R6 level drop", match, 0); chk("R11 vec idle", vec, 0);

      // R7: vector mode with latch bit
      quiesce();
      cfg(2'd0, 8'h0F);
      step(8'hFF, 1'b0); chk("R7 no flag", match, 0); chk("R7 port_q", port_q, 8'hFF);

      // R8: disabled mode
      quiesce();
      cfg(2'd0, 8'h08);
      step(8'hFF, 1'b0); chk("R8 disabled", match, 0);
      step(8'h00, 1'b0); chk("R8 disabled fall", match, 0);

      // R10: latch in AND mode, bit0 rising
      quiesce();
      cfg(2'd1, 8'h01); cfg(2'd2, 8'h01); cfg(2'd3, 8'h01); cfg(2'd0, 8'h0B);
      step(8'h41, 1'b0); chk("R10 set", match, 1); chk("R10 captured", port_q, 8'h41);
      step(8'h7E, 1'b0); chk("R10 held", port_q, 8'h41);
      step(8'h7E, 1'b1); chk("R10 cleared", match, 0); chk("R10 transparent", port_q, 8'h7E);

      // R9: interrupt disabled
      quiesce();
      cfg(2'd0, 8'h02);
      step(8'h01, 1'b0); chk("R9 flag", match, 1); chk("R9 irq off", irq, 0);

      // R3: AND with no participating bit
      quiesce();
      cfg(2'd2, 8'h00); cfg(2'd3, 8'h00); cfg(2'd0, 8'h0A);
      step(8'hFF, 1'b0); chk("R3 empty and", match, 0);
      step(8'h00, 1'b0); chk("R3 empty and fall", match, 0);

      done = 1'b1;
      summary();
   end
endmodule